// File: doc/BRIEF.md
# Target and Range Compare Interrupt Unit

This block watches the 32-bit present value of a pulse counter and raises interrupt requests, each tagged with a task number. It holds two tables, both loaded through one write port.

- The target table has 48 entries. Each entry is a compare value with a task number. An entry fires once, when the count arrives at its value.
- The range table has 8 entries. Each entry is a lower bound, an upper bound and a task number. An entry fires when the count moves into its window.

Requests queue as pending bits and leave one at a time over a valid/ready handshake. Each request carries its task number and a flag that tells a range request from a target request.

A configuration input selects what happens when the counter is reset:
- In continue mode, comparison keeps running.
- In stop mode, comparison halts until software pulses an enable input.

A second input selects signed or unsigned window bounds, to match a counter that runs in linear (signed) or ring (unsigned) mode.

Top module: `cmp_irq_unit`

## Requirements
- R1: A valid target entry raises one request, with `irq_is_range`=0 and its task number, when `pv` changes to equal its value. The entry raises no further request while `pv` stays equal. It can fire again only after `pv` has moved away and returned.
- R2: When several requests become pending together, the unit delivers all target requests before any range request. Within each table it delivers them in ascending index order. No request is lost.
- R3: A valid range entry raises one request, with `irq_is_range`=1 and its task number, when `pv` enters the closed window lower <= `pv` <= upper. The entry raises nothing while `pv` stays inside, and fires again on a later re-entry.
- R4: When `signed_mode`=1, window bounds and `pv` compare as two's-complement numbers. When `signed_mode`=0, they compare as unsigned numbers. A window whose lower bound is -10 and upper bound is 10 therefore contains 0 only in signed mode.
- R5: While `irq_valid`=1 and `irq_ready`=0, `irq_valid`, `irq_task` and `irq_is_range` hold steady. A request is consumed on a clock edge where both `irq_valid` and `irq_ready` are 1.
- R6: When `stop_cfg`=0, a `cnt_reset` pulse has no effect on comparison.
- R7: When `stop_cfg`=1, a `cnt_reset` pulse stops new requests from being raised. This lasts until an `enable_set` pulse. If `cnt_reset` and `enable_set` arrive in the same cycle, `cnt_reset` wins.
- R8: The write port acts on the clock edge where `wr_en`=1, according to `wr_kind`:
  - 0 loads target[`wr_addr`] with value `wr_data` and task `wr_task`, and makes it valid.
  - 1 loads the lower bound of range[`wr_addr`].
  - 2 loads the upper bound and task of range[`wr_addr`], and makes it valid.
  - 3 invalidates target[`wr_addr`] and range[`wr_addr`].
  An invalid entry never fires.
- R9: After reset, `irq_valid`=0, all entries are invalid and comparison is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pv | input | 32 | Counter present value |
| signed_mode | input | 1 | 1: signed window compare, 0: unsigned |
| stop_cfg | input | 1 | 1: a counter reset halts comparison |
| cnt_reset | input | 1 | Counter reset strobe |
| enable_set | input | 1 | Re-enable pulse after a halt |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | Write operation (see R8) |
| wr_addr | input | 6 | Entry index |
| wr_data | input | 32 | Compare value or bound |
| wr_task | input | 8 | Task number |
| irq_valid | output | 1 | Request available |
| irq_ready | input | 1 | Consumer accepts request |
| irq_task | output | 8 | Task number of the request |
| irq_is_range | output | 1 | 1: range request, 0: target request |

## Verification
The count first dwells on a value that two targets and one window share. This separates simultaneous-match ordering from single firing, and a long dwell shows that nothing fires a second time. Leaving and re-entering the value and the window distinguishes edge behaviour from level behaviour. A value that lies inside a window only when read as signed tells the two compare modes apart. Reset pulses in each configuration, and a cleared entry, show whether comparison halts, keeps running, or skips invalid entries. A held `irq_ready` shows whether a stalled request stays steady.

// File: rtl/cmp_irq_pkg.sv
// Shared constants and helpers for the compare interrupt unit.
// Assumes a 32-bit present value.
package cmp_irq_pkg;
    localparam int VAL_W = 32;

    localparam logic [1:0] WR_TGT = 2'd0;
    localparam logic [1:0] WR_RLO = 2'd1;
    localparam logic [1:0] WR_RHI = 2'd2;
    localparam logic [1:0] WR_CLR = 2'd3;

    // Less-or-equal test, signed or unsigned as selected
    function automatic logic val_le(input logic [VAL_W-1:0] a,
                                    input logic [VAL_W-1:0] b,
                                    input logic sgn);
        if (sgn) return $signed(a) <= $signed(b);
        return a <= b;
    endfunction
endpackage

// File: rtl/cmp_target_bank.sv
// Target table: one equality comparator per entry.
// A pending bit is set when an entry's match flag rises while comparison
// is enabled. The arbiter clears a pending bit through clr.
// Assumes wr_addr is below N_TGT for target writes.
module cmp_target_bank
    import cmp_irq_pkg::*;
#(
    parameter int N_TGT  = 48,
    parameter int TASK_W = 8,
    parameter int AW     = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [VAL_W-1:0]             pv,
    input  logic                         cmp_en,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_kind,
    input  logic [AW-1:0]                wr_addr,
    input  logic [VAL_W-1:0]             wr_data,
    input  logic [TASK_W-1:0]            wr_task,
    input  logic [N_TGT-1:0]             clr,
    output logic [N_TGT-1:0]             pend,
    output logic [N_TGT-1:0][TASK_W-1:0] tasks
);
    logic [N_TGT-1:0][VAL_W-1:0]  val_q;
    logic [N_TGT-1:0][TASK_W-1:0] task_q;
    logic [N_TGT-1:0]             vld_q, eq_q, eq_now, pend_q;

    // Per-entry equality compare against the present value
    for (genvar g = 0; g < N_TGT; g++) begin : g_eq
        assign eq_now[g] = vld_q[g] && (pv == val_q[g]);
    end

    // Table writes, match history and pending-bit update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            task_q <= '0;
            vld_q  <= '0;
            eq_q   <= '0;
            pend_q <= '0;
        end else begin
            for (int i = 0; i < N_TGT; i++) begin
                if (wr_en && wr_addr == AW'(i)) begin
                    if (wr_kind == WR_TGT) begin
                        val_q[i]  <= wr_data;
                        task_q[i] <= wr_task;
                        vld_q[i]  <= 1'b1;
                    end else if (wr_kind == WR_CLR) begin
                        vld_q[i]  <= 1'b0;
                    end
                end
            end
            eq_q   <= eq_now;
            pend_q <= (pend_q & ~clr) | (eq_now & ~eq_q & {N_TGT{cmp_en}});
        end
    end

    assign pend  = pend_q;
    assign tasks = task_q;

    // R1: a new pending bit only appears where the match flag has just risen
    a_r1_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q)) & ~(eq_q & ~$past(eq_q))) == '0);
    // R7: while comparison is halted, no pending bit is newly raised
    a_r7_tgt_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/cmp_range_bank.sv
// Range table: a closed-window compare per entry, signed or unsigned.
// A pending bit is set when the present value enters a window while
// comparison is enabled. The arbiter clears a pending bit through clr.
module cmp_range_bank
    import cmp_irq_pkg::*;
#(
    parameter int N_RNG  = 8,
    parameter int TASK_W = 8,
    parameter int AW     = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [VAL_W-1:0]             pv,
    input  logic                         signed_mode,
    input  logic                         cmp_en,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_kind,
    input  logic [AW-1:0]                wr_addr,
    input  logic [VAL_W-1:0]             wr_data,
    input  logic [TASK_W-1:0]            wr_task,
    input  logic [N_RNG-1:0]             clr,
    output logic [N_RNG-1:0]             pend,
    output logic [N_RNG-1:0][TASK_W-1:0] tasks
);
    logic [N_RNG-1:0][VAL_W-1:0]  lo_q, hi_q;
    logic [N_RNG-1:0][TASK_W-1:0] task_q;
    logic [N_RNG-1:0]             vld_q, in_q, in_now, pend_q;

    // Per-entry window test: lower <= pv <= upper
    for (genvar g = 0; g < N_RNG; g++) begin : g_win
        assign in_now[g] = vld_q[g]
                         && val_le(lo_q[g], pv, signed_mode)
                         && val_le(pv, hi_q[g], signed_mode);
    end

    // Table writes, inside history and pending-bit update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            task_q <= '0;
            vld_q  <= '0;
            in_q   <= '0;
            pend_q <= '0;
        end else begin
            for (int i = 0; i < N_RNG; i++) begin
                if (wr_en && wr_addr == AW'(i)) begin
                    if (wr_kind == WR_RLO) begin
                        lo_q[i]   <= wr_data;
                    end else if (wr_kind == WR_RHI) begin
                        hi_q[i]   <= wr_data;
                        task_q[i] <= wr_task;
                        vld_q[i]  <= 1'b1;
                    end else if (wr_kind == WR_CLR) begin
                        vld_q[i]  <= 1'b0;
                    end
                end
            end
            in_q   <= in_now;
            pend_q <= (pend_q & ~clr) | (in_now & ~in_q & {N_RNG{cmp_en}});
        end
    end

    assign pend  = pend_q;
    assign tasks = task_q;

    // R3: a new pending bit only appears on entry into a window
    a_r3_entry_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q)) & ~(in_q & ~$past(in_q))) == '0);
    // R7: while comparison is halted, no window entry is recorded
    a_r7_rng_halt: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/cmp_irq_arbiter.sv
// Chooses the next pending request and holds it on a valid/ready output.
// Targets take priority over ranges, and the lowest index wins in each
// table. A new request loads when the output register is empty or is
// being consumed.
module cmp_irq_arbiter #(
    parameter int N_TGT  = 48,
    parameter int N_RNG  = 8,
    parameter int TASK_W = 8,
    parameter int AW     = 6,
    parameter int RAW    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_TGT-1:0]             tgt_pend,
    input  logic [N_RNG-1:0]             rng_pend,
    input  logic [N_TGT-1:0][TASK_W-1:0] tgt_tasks,
    input  logic [N_RNG-1:0][TASK_W-1:0] rng_tasks,
    output logic [N_TGT-1:0]             tgt_clr,
    output logic [N_RNG-1:0]             rng_clr,
    output logic                         irq_valid,
    input  logic                         irq_ready,
    output logic [TASK_W-1:0]            irq_task,
    output logic                         irq_is_range
);
    logic [AW-1:0]     t_sel;
    logic [RAW-1:0]    r_sel;
    logic              load, t_any, r_any;
    logic              valid_q, rng_q;
    logic [TASK_W-1:0] task_q;

    assign t_any = |tgt_pend;
    assign r_any = |rng_pend;
    assign load  = !valid_q || irq_ready;

    // Lowest-index pick in each table
    always_comb begin
        t_sel = '0;
        for (int i = N_TGT - 1; i >= 0; i--) begin
            if (tgt_pend[i]) t_sel = AW'(i);
        end
        r_sel = '0;
        for (int i = N_RNG - 1; i >= 0; i--) begin
            if (rng_pend[i]) r_sel = RAW'(i);
        end
    end

    // Grant vectors that clear the chosen pending bit
    always_comb begin
        tgt_clr = '0;
        rng_clr = '0;
        if (load) begin
            if (t_any)      tgt_clr[t_sel] = 1'b1;
            else if (r_any) rng_clr[r_sel] = 1'b1;
        end
    end

    // Output register of the handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            rng_q   <= 1'b0;
            task_q  <= '0;
        end else if (load) begin
            valid_q <= t_any || r_any;
            rng_q   <= !t_any;
            task_q  <= t_any ? tgt_tasks[t_sel] : rng_tasks[r_sel];
        end
    end

    assign irq_valid    = valid_q;
    assign irq_task     = task_q;
    assign irq_is_range = rng_q;

    // R5: a stalled request stays steady
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_task)
                                       && $stable(irq_is_range)));
    // R2: at most one pending bit is granted per cycle
    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tgt_clr, rng_clr}));
    // R2: a range is granted only when no target is pending
    a_r2_tgt_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|rng_clr) |-> !(|tgt_pend));
endmodule

// File: rtl/cmp_irq_unit.sv
// Top level of the target and range compare interrupt unit.
// Holds the comparison-enable state that counter resets act on in stop
// mode, and connects the two tables to the request arbiter.
module cmp_irq_unit
    import cmp_irq_pkg::*;
#(
    parameter int N_TGT  = 48,
    parameter int N_RNG  = 8,
    parameter int TASK_W = 8,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       pv,
    input  logic              signed_mode,
    input  logic              stop_cfg,
    input  logic              cnt_reset,
    input  logic              enable_set,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [AW-1:0]     wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [TASK_W-1:0] wr_task,
    output logic              irq_valid,
    input  logic              irq_ready,
    output logic [TASK_W-1:0] irq_task,
    output logic              irq_is_range
);
    localparam int RAW = (N_RNG > 1) ? $clog2(N_RNG) : 1;

    logic                         en_q;
    logic [N_TGT-1:0]             t_pend, t_clr;
    logic [N_RNG-1:0]             r_pend, r_clr;
    logic [N_TGT-1:0][TASK_W-1:0] t_tasks;
    logic [N_RNG-1:0][TASK_W-1:0] r_tasks;

    // Comparison enable: dropped by a counter reset in stop mode, restored by software
    always_ff @(posedge clk) begin
        if (!rst_n)                       en_q <= 1'b1;
        else if (cnt_reset && stop_cfg)   en_q <= 1'b0;
        else if (enable_set)              en_q <= 1'b1;
    end

    cmp_target_bank #(.N_TGT(N_TGT), .TASK_W(TASK_W), .AW(AW)) u_tgt (
        .clk(clk), .rst_n(rst_n), .pv(pv), .cmp_en(en_q),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_task(wr_task),
        .clr(t_clr), .pend(t_pend), .tasks(t_tasks)
    );

    cmp_range_bank #(.N_RNG(N_RNG), .TASK_W(TASK_W), .AW(AW)) u_rng (
        .clk(clk), .rst_n(rst_n), .pv(pv), .signed_mode(signed_mode),
        .cmp_en(en_q), .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_task(wr_task),
        .clr(r_clr), .pend(r_pend), .tasks(r_tasks)
    );

    cmp_irq_arbiter #(.N_TGT(N_TGT), .N_RNG(N_RNG), .TASK_W(TASK_W),
                      .AW(AW), .RAW(RAW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .tgt_pend(t_pend), .rng_pend(r_pend),
        .tgt_tasks(t_tasks), .rng_tasks(r_tasks),
        .tgt_clr(t_clr), .rng_clr(r_clr),
        .irq_valid(irq_valid), .irq_ready(irq_ready),
        .irq_task(irq_task), .irq_is_range(irq_is_range)
    );

    // R6: only a reset in stop mode can drop the enable
    a_r6_keep_on: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !(cnt_reset && stop_cfg)) |=> en_q);
    // R7: once halted, only an enable pulse restores comparison
    a_r7_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !enable_set) |=> !en_q);
endmodule

// File: tb/sim_cmp_irq_unit.sv
// Scoreboard bench: driver steps push expected requests, a monitor pops them
module sim_cmp_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pv = '0;
    logic        signed_mode = 1'b0, stop_cfg = 1'b0, cnt_reset = 1'b0, enable_set = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  wr_task = '0;
    logic        irq_valid, irq_ready = 1'b1, irq_is_range;
    logic [7:0]  irq_task;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [8:0] exp_q[$];

    always #2.5 clk = ~clk;

    cmp_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pv(pv), .signed_mode(signed_mode),
        .stop_cfg(stop_cfg), .cnt_reset(cnt_reset), .enable_set(enable_set),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_task(wr_task), .irq_valid(irq_valid), .irq_ready(irq_ready),
        .irq_task(irq_task), .irq_is_range(irq_is_range)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] k, input logic [5:0] a,
                      input logic [31:0] d, input logic [7:0] t);
        step();
        wr_en = 1'b1; wr_kind = k; wr_addr = a; wr_data = d; wr_task = t;
        step();
        wr_en = 1'b0;
    endtask

    task automatic expect_irq(input logic rng, input logic [7:0] t);
        exp_q.push_back({rng, t});
    endtask

    task automatic set_pv(input logic [31:0] v, input int settle);
        step();
        pv = v;
        repeat (settle) step();
    endtask

    task automatic pulse(ref logic s);
        step(); s = 1'b1; step(); s = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Everything expected so far must have been delivered, with nothing further
    task automatic check_drained(input string req);
        @(negedge clk);
        check(exp_q.size() == 0 && !irq_valid, req, exp_q.size() + int'(irq_valid), 0);
    endtask

    // Monitor: each handshake must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && irq_valid && irq_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R1/R3 unexpected request", {irq_is_range, irq_task}, -1);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({irq_is_range, irq_task} == e, "R2 order/content",
                      {irq_is_range, irq_task}, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        @(negedge clk);
        check(irq_valid == 1'b0, "R9 valid low in reset", int'(irq_valid), 0);
        step(); rst_n = 1'b1;
        // R9: empty tables never fire
        set_pv(32'd5, 3);
        set_pv(32'd0, 6);
        check_drained("R9 empty tables silent");

        // R8: table loads
        wr(2'd0, 6'd0, 32'd100, 8'd5);
        wr(2'd0, 6'd3, 32'd100, 8'd7);
        wr(2'd0, 6'd1, 32'd200, 8'd9);
        wr(2'd0, 6'd47, 32'hFFFF_FFFB, 8'd3);
        wr(2'd1, 6'd0, 32'd50, 8'd0);
        wr(2'd2, 6'd0, 32'd150, 8'd20);
        wr(2'd1, 6'd2, 32'hFFFF_FFF6, 8'd0);
        wr(2'd2, 6'd2, 32'd10, 8'd22);

        // R1 R2 R3: two targets and one window together
        expect_irq(0, 8'd5); expect_irq(0, 8'd7); expect_irq(1, 8'd20);
        set_pv(32'd100, 12);
        check_drained("R1 no refire while equal");
        set_pv(32'd120, 6);
        check_drained("R3 no refire inside window");
        expect_irq(0, 8'd9);
        set_pv(32'd200, 8);
        check_drained("R1 move to second target");
        expect_irq(0, 8'd5); expect_irq(0, 8'd7); expect_irq(1, 8'd20);
        set_pv(32'd100, 10);
        check_drained("R3 re-entry fires again");

        // R5: back-pressure
        step(); irq_ready = 1'b0;
        expect_irq(0, 8'd9);
        set_pv(32'd200, 6);
        @(negedge clk);
        check(irq_valid && irq_task == 8'd9 && !irq_is_range, "R5 held request",
              {irq_valid, irq_task}, {1'b1, 8'd9});
        repeat (3) step();
        @(negedge clk);
        check(irq_valid && irq_task == 8'd9, "R5 still held", {irq_valid, irq_task}, {1'b1, 8'd9});
        step(); irq_ready = 1'b1;
        repeat (4) step();
        check_drained("R5 consumed once");

        // R4: window -10..10 holds 0 only when signed
        set_pv(32'd0, 6);
        check_drained("R4 unsigned excludes 0");
        set_pv(32'd300, 4);
        step(); signed_mode = 1'b1;
        expect_irq(1, 8'd22);
        set_pv(32'd0, 8);
        check_drained("R4 signed includes 0");
        expect_irq(0, 8'd3);
        set_pv(32'hFFFF_FFFB, 8);
        check_drained("R4 negative target, window kept");

        // R6: continue mode ignores counter reset
        pulse(cnt_reset);
        expect_irq(0, 8'd9);
        set_pv(32'd200, 8);
        check_drained("R6 continue after reset");

        // R7: stop mode halts until enable pulse
        step(); stop_cfg = 1'b1;
        pulse(cnt_reset);
        set_pv(32'd100, 10);
        check_drained("R7 halted after reset");
        pulse(enable_set);
        expect_irq(0, 8'd9);
        set_pv(32'd200, 8);
        check_drained("R7 resumes after enable");

        // R8: a cleared entry never fires
        wr(2'd3, 6'd1, 32'd0, 8'd0);
        expect_irq(0, 8'd5); expect_irq(0, 8'd7); expect_irq(1, 8'd20);
        set_pv(32'd100, 10);
        set_pv(32'd200, 10);
        check_drained("R8 cleared entry silent");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule